// File: doc/BRIEF.md
# Link Hot Reset State Controller

This controller runs the Hot Reset substate of a serial link port. An outer link-training machine hands it already-parsed training sets, one indication per lane: a valid strobe, the hot-reset flag, and the link and lane number fields. Once the outer machine enters the substate, the controller looks for two back-to-back matching hot-reset sets on any one lane. A match takes the link down. What happens next depends on the port. A higher layer may hold the port in Hot Reset. A bridge port forwards the reset downstream for a fixed dwell. Otherwise the controller moves straight on to Detect. If no match arrives within the dwell, it moves to Detect anyway.

Software can also start a hot reset through a secondary-bus-reset control bit. The controller then asks the transmitter to send hot-reset sets for as long as the bit stays set. Every sequence lasts at least a minimum assertion time, so a very short software pulse still produces a complete reset. Each exit to Detect is reported as a single-cycle pulse, after which the controller is idle until it is entered again.

Top module: `hot_reset_ctrl`

## Requirements
- R1: After reset, `link_up_o`, `tx_hr_o` and `detect_o` are all 0.
- R2: While waiting after `enter_i`, a lane whose two most recent valid sets both match takes `link_up_o` to 0 on the next cycle. A set matches when its hot-reset flag is 1, its link field equals `cfg_link_i`, and its lane field equals that lane's index. Matches on two different lanes do not combine. `tx_hr_o` high always implies `link_up_o` low.
- R3: A valid set that does not match clears that lane's count. This covers a clear flag, a wrong link field or a wrong lane field. After such a set, one further match does not recognise hot reset.
- R4: On recognition with `hold_i`=0 and `bridge_i`=0, `detect_o` pulses high for exactly one cycle, in the cycle after recognition. `tx_hr_o` stays 0.
- R5: On recognition with `hold_i`=1, `tx_hr_o` is 1 and `detect_o` stays 0 for as long as `hold_i` stays 1. The cycle after `hold_i` is sampled low, `tx_hr_o` drops and `detect_o` pulses.
- R6: If no recognition happens, `detect_o` pulses exactly `DWELL_CYC` cycles after the edge that sampled `enter_i`. `link_up_o` is unchanged.
- R7: On recognition with `bridge_i`=1 and `hold_i`=0, `tx_hr_o` is 1 for exactly `DWELL_CYC` cycles. It then falls in the same cycle that `detect_o` pulses. `tx_hr_o` never falls without a `detect_o` pulse.
- R8: A rising edge of `sbr_i` while idle raises `tx_hr_o` and drops `link_up_o` on the next cycle. If `sbr_i` stays set for at least `MIN_CYC` cycles, `tx_hr_o` falls in the cycle after `sbr_i` is sampled low, and `detect_o` pulses in that same cycle.
- R9: A `sbr_i` pulse shorter than `MIN_CYC` cycles still keeps `tx_hr_o` high for exactly `MIN_CYC` cycles, and then `detect_o` pulses.
- R10: `link_up_set_i` raises `link_up_o` on the next cycle only while the controller is idle or waiting. During transmission it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_i | input | 1 | Outer training machine enters the Hot Reset substate |
| ts_valid_i | input | LANES | A training set was received on this lane |
| ts_hr_i | input | LANES | Hot-reset flag of the set on each lane |
| ts_link_i | input | LANES*LINKW | Link number field, one slice per lane |
| ts_lane_i | input | LANES*LANEW | Lane number field, one slice per lane |
| cfg_link_i | input | LINKW | Configured link number |
| hold_i | input | 1 | Higher layer holds the port in Hot Reset |
| bridge_i | input | 1 | Port forwards hot reset downstream |
| sbr_i | input | 1 | Secondary-bus-reset control bit |
| link_up_set_i | input | 1 | Outer machine reports the link trained |
| link_up_o | output | 1 | LinkUp flag |
| tx_hr_o | output | 1 | Request to transmit hot-reset training sets |
| detect_o | output | 1 | One-cycle pulse: next state is Detect |

## Verification
The hardest case to reach is a near-miss in the consecutive-set count. The stimulus interleaves matching sets with sets that fail on exactly one field each: the flag, the link number or the lane number. It also places single matches on two different lanes next to each other. The design must then stay in its waiting state until a true back-to-back pair finally arrives. The short and long secondary-bus-reset pulses are timed against the minimum window, cycle by cycle, so that both the stretched exit and the prompt exit are observed.

// File: rtl/hot_reset_ctrl.sv
module hot_reset_ctrl #(
  parameter int LANES     = 4,
  parameter int LINKW     = 8,
  parameter int LANEW     = 5,
  parameter int DWELL_CYC = 500000,
  parameter int MIN_CYC   = 250000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enter_i,
  input  logic [LANES-1:0]       ts_valid_i,
  input  logic [LANES-1:0]       ts_hr_i,
  input  logic [LANES*LINKW-1:0] ts_link_i,
  input  logic [LANES*LANEW-1:0] ts_lane_i,
  input  logic [LINKW-1:0]       cfg_link_i,
  input  logic                   hold_i,
  input  logic                   bridge_i,
  input  logic                   sbr_i,
  input  logic                   link_up_set_i,
  output logic                   link_up_o,
  output logic                   tx_hr_o,
  output logic                   detect_o
);
  localparam int TW = $clog2(DWELL_CYC + 1);
  localparam logic [TW-1:0] DW_LAST  = TW'(DWELL_CYC - 1);
  localparam logic [TW-1:0] MIN_LAST = TW'(MIN_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_HOLD, S_PROP, S_DRIVE} st_t;

  st_t             state;
  logic [TW-1:0]   timer;
  logic            sbr_q;
  logic [LANES-1:0] hit;
  logic            recog;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic seen;
    logic match;
    assign match = ts_hr_i[g]
                 && (ts_link_i[g*LINKW +: LINKW] == cfg_link_i)
                 && (ts_lane_i[g*LANEW +: LANEW] == LANEW'(g));
    assign hit[g] = (state == S_WAIT) && ts_valid_i[g] && match && seen;
    always_ff @(posedge clk) begin
      if (!rst_n || state != S_WAIT) seen <= 1'b0;
      else if (ts_valid_i[g])        seen <= match;
    end
  end

  assign recog   = |hit;
  assign tx_hr_o = (state == S_HOLD) || (state == S_PROP) || (state == S_DRIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      timer     <= '0;
      sbr_q     <= 1'b0;
      link_up_o <= 1'b0;
      detect_o  <= 1'b0;
    end else begin
      detect_o <= 1'b0;
      sbr_q    <= sbr_i;
      if (link_up_set_i && (state == S_IDLE || state == S_WAIT)) link_up_o <= 1'b1;
      case (state)
        S_IDLE: begin
          if (sbr_i && !sbr_q) begin
            state     <= S_DRIVE;
            timer     <= '0;
            link_up_o <= 1'b0;
          end else if (enter_i) begin
            state <= S_WAIT;
            timer <= '0;
          end
        end
        S_WAIT: begin
          if (recog) begin
            link_up_o <= 1'b0;
            if (hold_i) state <= S_HOLD;
            else if (bridge_i) begin
              state <= S_PROP;
              timer <= '0;
            end else begin
              state    <= S_IDLE;
              detect_o <= 1'b1;
            end
          end else if (timer == DW_LAST) begin
            state    <= S_IDLE;
            detect_o <= 1'b1;
          end else timer <= timer + 1'b1;
        end
        S_HOLD: begin
          if (!hold_i) begin
            state    <= S_IDLE;
            detect_o <= 1'b1;
          end
        end
        S_PROP: begin
          if (timer == DW_LAST) begin
            state    <= S_IDLE;
            detect_o <= 1'b1;
          end else timer <= timer + 1'b1;
        end
        S_DRIVE: begin
          if (!sbr_i && timer == MIN_LAST) begin
            state    <= S_IDLE;
            detect_o <= 1'b1;
          end else if (timer != MIN_LAST) timer <= timer + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hot_reset_ctrl_chk.sv
module hot_reset_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic link_up_set_i,
  input logic link_up_o,
  input logic tx_hr_o,
  input logic detect_o
);
  p_detect_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |=> !detect_o);

  p_tx_linkdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hr_o |-> !link_up_o);

  p_tx_end_detect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_hr_o) |-> detect_o);

  p_detect_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |-> !tx_hr_o);

  p_link_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up_o) |-> $past(link_up_set_i));
endmodule

bind hot_reset_ctrl hot_reset_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .link_up_set_i(link_up_set_i),
  .link_up_o(link_up_o), .tx_hr_o(tx_hr_o), .detect_o(detect_o)
);

// File: tb/hot_reset_ctrl_tb.sv
module hot_reset_ctrl_tb;
  localparam int LANES = 2;
  localparam int DW    = 40;
  localparam int MN    = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter = 0, hold = 0, bridge = 0, sbr = 0, lu_set = 0;
  logic [LANES-1:0] tv = '0, thr = '0;
  logic [LANES*8-1:0] tlink = '0;
  logic [LANES*5-1:0] tlane = '0;
  logic lu, tx, det;

  always #2 clk = ~clk;

  hot_reset_ctrl #(.LANES(LANES), .LINKW(8), .LANEW(5), .DWELL_CYC(DW), .MIN_CYC(MN)) u_dut (
    .clk(clk), .rst_n(rst_n), .enter_i(enter), .ts_valid_i(tv), .ts_hr_i(thr),
    .ts_link_i(tlink), .ts_lane_i(tlane), .cfg_link_i(8'h05), .hold_i(hold),
    .bridge_i(bridge), .sbr_i(sbr), .link_up_set_i(lu_set),
    .link_up_o(lu), .tx_hr_o(tx), .detect_o(det));

  typedef struct { int cyc; bit tx; bit lu; bit det; string rid; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, failures = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        checks++;
        if (tx !== q[i].tx || lu !== q[i].lu || det !== q[i].det) begin
          failures++;
          $display("FAIL %s cyc=%0d actual tx=%b lu=%b det=%b expected tx=%b lu=%b det=%b",
                   q[i].rid, cyc, tx, lu, det, q[i].tx, q[i].lu, q[i].det);
        end
        q.delete(i);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(int d, bit etx, bit elu, bit edet, string rid);
    exp_t e;
    e.cyc = cyc + d; e.tx = etx; e.lu = elu; e.det = edet; e.rid = rid;
    q.push_back(e);
  endtask

  task automatic ts(int lane, bit hr, logic [7:0] link, logic [4:0] lf,
                    bit etx, bit elu, bit edet, string rid);
    tv = '0; thr = '0;
    tv[lane] = 1'b1; thr[lane] = hr;
    tlink[lane*8 +: 8] = link;
    tlane[lane*5 +: 5] = lf;
    expect_at(1, etx, elu, edet, rid);
    tick();
    tv = '0;
  endtask

  task automatic link_on_and_enter();
    lu_set = 1; expect_at(1, 0, 1, 0, "R10"); tick(); lu_set = 0;
    enter = 1; tick(); enter = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_at(1, 0, 0, 0, "R1");
    rst_n = 1;
    tick(2);

    // R2 / R4: plain recognition on lane 1
    link_on_and_enter();
    ts(1, 1, 8'h05, 5'd1, 0, 1, 0, "R2");
    expect_at(2, 0, 0, 0, "R4");
    ts(1, 1, 8'h05, 5'd1, 0, 0, 1, "R2");
    tick(3);

    // R3: near misses on every field, and across lanes
    link_on_and_enter();
    ts(0, 1, 8'h05, 5'd0, 0, 1, 0, "R3");
    ts(0, 1, 8'h06, 5'd0, 0, 1, 0, "R3");
    ts(0, 1, 8'h05, 5'd0, 0, 1, 0, "R3");
    ts(0, 1, 8'h05, 5'd1, 0, 1, 0, "R3");
    ts(0, 1, 8'h05, 5'd0, 0, 1, 0, "R3");
    ts(0, 0, 8'h05, 5'd0, 0, 1, 0, "R3");
    ts(0, 1, 8'h05, 5'd0, 0, 1, 0, "R3");
    ts(1, 1, 8'h05, 5'd1, 0, 1, 0, "R2");
    ts(0, 1, 8'h05, 5'd0, 0, 0, 1, "R3");
    tick(3);

    // R5: higher-layer hold, with an ignored link_up_set (R10)
    link_on_and_enter();
    hold = 1;
    ts(0, 1, 8'h05, 5'd0, 0, 1, 0, "R5");
    ts(0, 1, 8'h05, 5'd0, 1, 0, 0, "R5");
    for (int k = 0; k < 10; k++) begin
      if (k == 4) lu_set = 1;
      expect_at(1, 1, 0, 0, (k == 4) ? "R10" : "R5");
      tick();
      lu_set = 0;
    end
    hold = 0;
    expect_at(1, 0, 0, 1, "R5");
    expect_at(2, 0, 0, 0, "R5");
    tick(4);

    // R6: timeout without recognition
    lu_set = 1; tick(); lu_set = 0;
    enter = 1;
    expect_at(DW, 0, 1, 0, "R6");
    expect_at(DW + 1, 0, 1, 1, "R6");
    expect_at(DW + 2, 0, 1, 0, "R6");
    tick(); enter = 0;
    tick(DW + 4);

    // R7: bridge propagation window
    bridge = 1;
    link_on_and_enter();
    ts(1, 1, 8'h05, 5'd1, 0, 1, 0, "R7");
    tv[1] = 1; thr[1] = 1;
    expect_at(1, 1, 0, 0, "R7");
    expect_at(DW, 1, 0, 0, "R7");
    expect_at(DW + 1, 0, 0, 1, "R7");
    expect_at(DW + 2, 0, 0, 0, "R7");
    tick(); tv = '0; bridge = 0;
    tick(DW + 4);

    // R8: long secondary-bus-reset assertion
    lu_set = 1; tick(); lu_set = 0;
    sbr = 1;
    expect_at(1, 1, 0, 0, "R8");
    tick(MN + 10);
    expect_at(0, 1, 0, 0, "R8");
    sbr = 0;
    expect_at(1, 0, 0, 1, "R8");
    expect_at(2, 0, 0, 0, "R8");
    tick(4);

    // R9: short pulse stretched to the minimum
    lu_set = 1; tick(); lu_set = 0;
    sbr = 1;
    expect_at(1, 1, 0, 0, "R9");
    expect_at(MN, 1, 0, 0, "R9");
    expect_at(MN + 1, 0, 0, 1, "R9");
    expect_at(MN + 2, 0, 0, 0, "R9");
    tick(); sbr = 0;
    tick(MN + 4);

    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard left %0d unchecked items", q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule